// File: doc/BRIEF.md
# Sequenced RGB Colour Table Register Port

This block holds a 260-entry colour lookup table. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Entries 0 to 255 are the pixel colours. Entries 256 to 259 are the overlay and cursor colours.

Software talks to the table through a 32-bit register bus with a 16-byte window. It first loads an entry number. It then moves through red, green and blue, one bus access per component. After the third component the entry number steps forward by itself. A separate write offset sends the same three-step sequence into one of the four overlay entries, chosen by the two low bits of the entry number.

A combinational lookup port lets scan-out logic fetch any entry as a 24-bit colour. Converting that colour to a display pixel format is left to the logic that uses it.

Top module: `pal_dac`

## Requirements
- R1: A full-word write at byte offset 0 loads the entry number from write data bits 31:24 and sets the component step to red. The new value is visible from the next access.
- R2: A full-word write at offset 4 stores write data bits 31:24 into the current component of entry [entry number]. The component step then advances from red to green, and from green to blue.
- R3: A full-word write at offset 12 follows the same sequence as offset 4, but it writes overlay entry 256 + (entry number & 3). It never changes entries 0 to 255.
- R4: After an access in the blue step, the step returns to red and the entry number increments modulo 256, so 255 is followed by 0.
- R5: A full-word read at any offset returns the current component of entry [entry number] in bits 31:24, with bits 23:0 zero. A read advances the step and entry number exactly as a write does. When no read is in progress, rdata is zero.
- R6: On synchronous reset every component is zero, except entries 255, 256 and 258, which are white (FF,FF,FF). The entry number and step are also cleared to 0 and red.
- R7: An access whose byte enables are not all four set (be != 4'hF) has no effect. A write at any offset other than 0, 4 or 12 also has no effect.
- R8: lk_rgb gives {red, green, blue} of entry lk_idx in bits 23:16, 15:8 and 7:0, in the same cycle, for any lk_idx up to 259. For lk_idx of 260 or more it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus access in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset in the 16-byte window |
| be | input | 4 | Byte enables; only 4'hF is a valid access |
| wdata | input | 32 | Write data; bits 31:24 are used |
| rdata | output | 32 | Read data, combinational during a read |
| lk_idx | input | 9 | Scan-out entry number |
| lk_rgb | output | 24 | Scan-out colour of entry lk_idx |

## Verification
A wrong entry number or component step does not stay hidden. It shows up on the very next bus access: a read returns a component from the wrong entry or the wrong colour, and a write lands in a place that lk_rgb exposes in the cycle after the write. The expected values come from a reference model kept in the bench, and the lookup port is checked after each sequence. Wrap from entry 255 to 0, overlay redirection, partial-enable and wrong-offset accesses, and reset from a state other than the idle one are each followed at once by a read or a lookup. That read or lookup would reveal any corrupted state.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

    localparam int CW = 8;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
    } rgb_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic logic [CW-1:0] pick_comp(input rgb_t c, input phase_e p);
        case (p)
            PH_RED:  return c.r;
            PH_GRN:  return c.g;
            default: return c.b;
        endcase
    endfunction

    function automatic rgb_t put_comp(input rgb_t c, input phase_e p,
                                      input logic [CW-1:0] v);
        rgb_t o;
        o = c;
        case (p)
            PH_RED:  o.r = v;
            PH_GRN:  o.g = v;
            default: o.b = v;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dac_seq.sv
module dac_seq
    import pal_dac_pkg::*;
#(
    parameter int BASE_N = 256,
    parameter int OVL_N  = 4,
    localparam int IDX_W = $clog2(BASE_N),
    localparam int SEL_W = $clog2(OVL_N),
    localparam int EW    = $clog2(BASE_N + OVL_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             ovl,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase,
    output logic [EW-1:0]    went
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (step) begin
            phase <= next_phase(phase);
            if (phase == PH_BLU) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        if (ovl) went = EW'(BASE_N) + EW'(idx[SEL_W-1:0]);
        else     went = EW'(idx);
    end

    // R1
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx == $past(load_val)) && (phase == PH_RED));

    // R2
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (step && !load && phase != PH_BLU) |=>
            (phase == next_phase($past(phase))) && $stable(idx));

    // R4
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !load && phase == PH_BLU) |=>
            (phase == PH_RED) && (idx == $past(idx) + 1'b1));

    // R7
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(idx) && $stable(phase));

endmodule

// File: rtl/dac_table.sv
module dac_table
    import pal_dac_pkg::*;
#(
    parameter int BASE_N = 256,
    parameter int OVL_N  = 4,
    localparam int N     = BASE_N + OVL_N,
    localparam int EW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_entry,
    input  phase_e        wr_ph,
    input  logic [CW-1:0] wr_val,
    input  logic [EW-1:0] rd_entry,
    input  phase_e        rd_ph,
    output logic [CW-1:0] rd_comp,
    input  logic [EW-1:0] lk_idx,
    output rgb_t          lk_rgb
);

    rgb_t mem [N];

    function automatic bit is_white(input int i);
        return (i == BASE_N - 1) || (i == BASE_N) || (i == BASE_N + 2);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                mem[i] <= is_white(i) ? '1 : '0;
        end else if (wr_en && (int'(wr_entry) < N)) begin
            mem[wr_entry] <= put_comp(mem[wr_entry], wr_ph, wr_val);
        end
    end

    always_comb begin
        rd_comp = '0;
        if (int'(rd_entry) < N) rd_comp = pick_comp(mem[rd_entry], rd_ph);
    end

    always_comb begin
        lk_rgb = '0;
        if (int'(lk_idx) < N) lk_rgb = mem[lk_idx];
    end

    // R2
    a_r2_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_entry) < N) |=>
            pick_comp(mem[$past(wr_entry)], $past(wr_ph)) == $past(wr_val));

endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_dac_pkg::*;
#(
    parameter int BASE_N = 256,
    parameter int OVL_N  = 4,
    parameter int DW     = 32,
    parameter int AW     = 4,
    localparam int BEW   = DW / 8,
    localparam int IDX_W = $clog2(BASE_N),
    localparam int EW    = $clog2(BASE_N + OVL_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [BEW-1:0] be,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [EW-1:0] lk_idx,
    output logic [3*CW-1:0] lk_rgb
);

    localparam logic [AW-1:0] OFF_IDX = AW'(0);
    localparam logic [AW-1:0] OFF_DAT = AW'(4);
    localparam logic [AW-1:0] OFF_OVL = AW'(12);

    logic full, do_load, do_wstep, do_rstep, do_step, is_ovl;
    logic [IDX_W-1:0] idx;
    phase_e phase;
    logic [EW-1:0] went;
    logic [CW-1:0] rd_comp;
    logic [CW-1:0] top_byte;
    rgb_t lk_c;
    logic unused_bits;

    assign top_byte    = wdata[DW-1 -: CW];
    assign unused_bits = ^wdata[DW-CW-1:0];

    assign full     = req && (be == '1);
    assign do_load  = full && we && (addr == OFF_IDX);
    assign do_wstep = full && we && ((addr == OFF_DAT) || (addr == OFF_OVL));
    assign do_rstep = full && !we;
    assign do_step  = do_wstep || do_rstep;
    assign is_ovl   = (addr == OFF_OVL);

    dac_seq #(.BASE_N(BASE_N), .OVL_N(OVL_N)) seq_i (
        .clk(clk), .rst(rst),
        .load(do_load), .step(do_step), .ovl(is_ovl),
        .load_val(top_byte[IDX_W-1:0]),
        .idx(idx), .phase(phase), .went(went)
    );

    dac_table #(.BASE_N(BASE_N), .OVL_N(OVL_N)) tbl_i (
        .clk(clk), .rst(rst),
        .wr_en(do_wstep), .wr_entry(went), .wr_ph(phase), .wr_val(top_byte),
        .rd_entry(EW'(idx)), .rd_ph(phase), .rd_comp(rd_comp),
        .lk_idx(lk_idx), .lk_rgb(lk_c)
    );

    assign rdata  = do_rstep ? {rd_comp, {(DW-CW){1'b0}}} : '0;
    assign lk_rgb = lk_c;

    // R5
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(req && !we) |-> (rdata == '0));

    // R3
    a_r3_overlay_target: assert property (@(posedge clk) disable iff (rst)
        (do_wstep && is_ovl) |-> (int'(went) >= BASE_N));

endmodule

// File: tb/pal_dac_tb_top.sv
module pal_dac_tb_top;

    logic clk = 0;
    logic rst, req, we;
    logic [3:0] addr, be;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [8:0] lk_idx;
    logic [23:0] lk_rgb;

    int total = 0, bad = 0;
    logic [23:0] m [260];
    int bidx = 0, bph = 0;

    always #2 clk = ~clk;

    pal_dac dut_i (.clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
                   .be(be), .wdata(wdata), .rdata(rdata),
                   .lk_idx(lk_idx), .lk_rgb(lk_rgb));

    localparam logic [31:0] VEC [6] = '{
        {8'd0,   24'h123456}, {8'd1,   24'hA5C30F}, {8'd17,  24'hFF0080},
        {8'd128, 24'h010203}, {8'd254, 24'h00FF00}, {8'd255, 24'h7E7E7E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 260; i++)
            m[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
        bidx = 0; bph = 0;
    endtask

    task automatic model_step();
        if (bph == 2) begin bph = 0; bidx = (bidx + 1) % 256; end
        else bph++;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] v, input logic [3:0] b);
        int e;
        @(negedge clk);
        req = 1; we = 1; addr = a; be = b; wdata = {v, 24'h5A5A5A};
        @(negedge clk);
        req = 0; we = 0;
        if (b == 4'hF) begin
            if (a == 0) begin bidx = v; bph = 0; end
            else if (a == 4 || a == 12) begin
                e = (a == 12) ? 256 + (bidx & 3) : bidx;
                m[e][23 - 8*bph -: 8] = v;
                model_step();
            end
        end
    endtask

    task automatic bus_rd(input string tag);
        logic [31:0] exp;
        @(negedge clk);
        req = 1; we = 0; addr = 4'd8; be = 4'hF;
        exp = {m[bidx][23 - 8*bph -: 8], 24'h0};
        #1 chk(tag, rdata, exp);
        @(negedge clk);
        req = 0;
        model_step();
    endtask

    task automatic look(input string tag, input int e);
        lk_idx = 9'(e);
        #1 chk(tag, {8'h0, lk_rgb}, {8'h0, (e < 260) ? m[e] : 24'h0});
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; req = 0; we = 0; addr = 0; be = 0; wdata = 0; lk_idx = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R6 reset state
        look("R6 entry0", 0); look("R6 entry255", 255);
        look("R6 entry256", 256); look("R6 entry257", 257);
        look("R6 entry258", 258); look("R6 entry259", 259);
        chk("R5 idle rdata", rdata, 32'h0);

        // R1 R2 vector walk
        foreach (VEC[i]) begin
            bus_wr(4'd0, VEC[i][31:24], 4'hF);
            bus_wr(4'd4, VEC[i][23:16], 4'hF);
            bus_wr(4'd4, VEC[i][15:8], 4'hF);
            bus_wr(4'd4, VEC[i][7:0], 4'hF);
            lk_idx = 9'(VEC[i][31:24]);
            #1 chk("R2 vector entry", {8'h0, lk_rgb}, {8'h0, VEC[i][23:0]});
        end

        // R4 wrap: after 255 the next access targets entry 0
        bus_rd("R4 wrap reads entry0 red");
        bus_rd("R5 read green");
        bus_rd("R5 read blue");
        bus_rd("R4 next entry1 red");

        // R3 overlay
        bus_wr(4'd0, 8'd6, 4'hF);
        bus_wr(4'd12, 8'h11, 4'hF);
        bus_wr(4'd12, 8'h22, 4'hF);
        bus_wr(4'd12, 8'h33, 4'hF);
        look("R3 overlay 258", 258);
        look("R3 base 6 untouched", 6);
        bus_wr(4'd12, 8'h44, 4'hF);
        look("R3 overlay 259 after step", 259);
        bus_rd("R3 index 7 green read");

        // R7 ignored accesses
        bus_wr(4'd0, 8'd200, 4'h7);
        bus_wr(4'd4, 8'hEE, 4'hE);
        bus_wr(4'd8, 8'hDD, 4'hF);
        bus_wr(4'd1, 8'hCC, 4'hF);
        look("R7 entry7 unchanged", 7);
        look("R7 entry200 unchanged", 200);
        bus_rd("R7 state kept blue of 7");
        bus_rd("R7 state kept entry8 red");

        // R8 lookup beyond the table
        look("R8 out of range 300", 300);
        look("R8 out of range 511", 511);
        look("R8 last entry", 259);

        // R6 reset from a busy state
        bus_wr(4'd0, 8'd9, 4'hF);
        bus_wr(4'd4, 8'h99, 4'hF);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_reset();
        look("R6 after reset entry0", 0);
        look("R6 after reset entry9", 9);
        look("R6 after reset entry256", 256);
        bus_wr(4'd4, 8'hAB, 4'hF);
        look("R6 index cleared write lands entry0", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule